// File: doc/BRIEF.md
# Vectorised Branch Condition Evaluator

This unit carries out one conditional branch across a vector of elements. A start pulse captures the branch options, the mode flags, the count register, the current instruction address, the displacement, the link register and the vector length. The unit then walks an element index from zero upward, one element per clock. For each element it reads a 32-bit condition word that the surrounding pipeline presents on `elem_cr`, chosen by the element index the unit shows on `step`.

On each element the count register can be decremented and tested for zero, and one condition bit is compared against a sense bit. The loop can stop early in three ways: the first element whose tests both pass takes the branch, a chosen pass or fail outcome cuts the vector length short, or, in all-elements mode, any failing element aborts. In all-elements mode the branch is only tried on the element that closes the loop.

When the loop finishes, `done` pulses for one cycle. The final next-instruction address, count register, optional vector-length write and optional link-register write are valid in that cycle and stay stable until the next start. A second variant takes its target from the link register and evaluates a single element.

Top module: `vbranch_eval`

## Requirements
- R1: The tested bit is `snz_in` when `sz_in` is 1 and `to_lr_in` is 0. Otherwise it is bit (31 - `bi_in`) of `elem_cr`, so that `bi_in` = 0 selects the most significant bit.
- R2: When `bo_in[1]` (keep-count) is 0, the count register is reduced by one for every processed element. When it is 1, the count is left unchanged.
- R3: The count test passes when `bo_in[1]` is 1, or when (decremented count is non-zero) XOR `bo_in[0]` is 1. The zero test covers all 64 bits when `mode64_in` is 1, and only bits 31..0 otherwise.
- R4: The condition test passes when `bo_in[3]` (ignore condition) is 1, or when the tested bit equals `bo_in[2]` (sense).
- R5: Outside all-elements mode, the first element that passes both tests takes the branch and ends the loop. The target is sign-extend(`disp_in` followed by two zero bits) when `abs_in` is 1, and `cia_in` plus that value otherwise.
- R6: When `vlset_in` is 1 and the combined pass outcome of an element equals `vl_sense_in`, the loop ends and `vl_we` pulses. `vl_out` is then the element index plus one if `vl_incl_in` is 1, and the element index otherwise.
- R7: In all-elements mode (`all_in` = 1) a branch is only tried on the element that ends the loop. Any element that fails either test ends the loop at once without branching.
- R8: `lr_we` pulses with `done` when `link_in` is 1 and either `lr_force_in` is 1 or the branch was taken. `lr_out` is then `cia_in` + 4.
- R9: With `to_lr_in` = 1, exactly one element is evaluated, the target is `lr_in` with its two low bits cleared, and the vector-length and all-elements controls have no effect.
- R10: A loop that ends without a taken branch gives `nia` = `cia_in` + 4 and `taken` = 0. `done` is high for exactly one cycle. A vector length of 0 (outside the link-register variant) processes no element and raises `done` in the cycle after start.
- R11: After the start edge, one element is processed per clock, starting at element 0. Element `vl_in` - 1 closes the loop, so `done` rises N cycles after the start edge when N elements are processed. A start pulse during a run is ignored.
- R12: Reset clears `busy`, `done`, `taken`, `vl_we` and `lr_we`, and abandons any loop in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Capture inputs and begin the loop |
| bo_in | input | 4 | Branch options: [3] ignore condition, [2] sense, [1] keep count, [0] branch on count zero |
| bi_in | input | 5 | Condition bit index, 0 = most significant |
| sz_in | input | 1 | Use `snz_in` as the tested bit |
| snz_in | input | 1 | Substitute tested bit |
| mode64_in | input | 1 | 64-bit count zero test |
| vlset_in | input | 1 | Enable vector-length truncation |
| vl_sense_in | input | 1 | Pass outcome that triggers truncation |
| vl_incl_in | input | 1 | Truncated length includes the current element |
| all_in | input | 1 | All-elements mode |
| lr_force_in | input | 1 | Write the link register even when not taken |
| link_in | input | 1 | Link-register write requested |
| abs_in | input | 1 | Absolute target |
| to_lr_in | input | 1 | Branch-to-link-register variant |
| vl_in | input | 7 | Vector length |
| ctr_in | input | 64 | Count register |
| cia_in | input | 64 | Current instruction address |
| disp_in | input | 14 | Word displacement |
| lr_in | input | 64 | Link register |
| elem_cr | input | 32 | Condition word of the element at `step` |
| busy | output | 1 | Loop in progress |
| step | output | 7 | Current element index |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch was taken |
| nia | output | 64 | Next instruction address |
| ctr_out | output | 64 | Updated count register |
| vl_we | output | 1 | Vector-length write strobe |
| vl_out | output | 7 | New vector length |
| lr_we | output | 1 | Link-register write strobe |
| lr_out | output | 64 | Link-register write value |

## Verification
Several properties are checked on every clock:
- `done` never lasts two cycles.
- The count drops by one per element when keep-count is clear.
- The element index advances by one per busy cycle.
- A not-taken completion always gives the fall-through address.
- The link value is always the return address.
- A vector-length write only comes with `done`, and its value matches the last element index.
- In all-elements mode a failing element always aborts without a branch.

The choice of tested bit, the 32-bit versus 64-bit zero test, which element wins, the relative, absolute and link targets, and the count of elements processed before `done` are only shown by the bench scenarios, which compare against hand-derived results.

// File: rtl/vbranch_pkg.sv
package vbranch_pkg;

    typedef struct packed {
        logic ign_cond;
        logic sense;
        logic keep_ctr;
        logic on_zero;
    } bo_t;

    typedef struct packed {
        logic sz;
        logic snz;
        logic m64;
        logic vlset;
        logic vsb;
        logic vli;
        logic all_el;
        logic lru;
        logic lk;
        logic aa;
        logic lrm;
    } mode_t;

    typedef struct packed {
        logic pass;
        logic vl_hit;
        logic take;
        logic finish;
    } verdict_t;

    typedef enum logic {ST_IDLE, ST_RUN} state_t;

    function automatic bo_t unpack_bo(input logic [3:0] raw);
        bo_t b;
        b.ign_cond = raw[3];
        b.sense    = raw[2];
        b.keep_ctr = raw[1];
        b.on_zero  = raw[0];
        return b;
    endfunction

endpackage

// File: rtl/vbr_elem_eval.sv
module vbr_elem_eval
    import vbranch_pkg::*;
#(
    parameter int AW   = 64,
    parameter int CR_W = 32,
    parameter int VL_W = 7,
    parameter int BI_W = $clog2(CR_W)
) (
    input  bo_t             bo,
    input  mode_t           md,
    input  logic [BI_W-1:0] bi,
    input  logic [CR_W-1:0] cr,
    input  logic [AW-1:0]   ctr,
    input  logic [VL_W-1:0] step,
    input  logic [VL_W-1:0] vl,
    output logic [AW-1:0]   ctr_nxt,
    output verdict_t        verd
);
    localparam int HALF_W = AW / 2;

    logic test_bit, nz, ctr_ok, cond_ok, closes, gate_all, try_br, abort;

    always_comb begin
        test_bit = (md.sz && !md.lrm) ? md.snz : cr[(CR_W-1) - int'(bi)];
        ctr_nxt  = bo.keep_ctr ? ctr : ctr - AW'(1);
        nz       = md.m64 ? (|ctr_nxt) : (|ctr_nxt[HALF_W-1:0]);
        ctr_ok   = bo.keep_ctr | (nz ^ bo.on_zero);
        cond_ok  = bo.ign_cond | ~(test_bit ^ bo.sense);

        verd.pass   = ctr_ok & cond_ok;
        verd.vl_hit = !md.lrm & md.vlset & (verd.pass == md.vsb);
        closes      = verd.vl_hit | (step == vl - VL_W'(1)) | md.lrm;
        gate_all    = md.all_el & !md.lrm;
        try_br      = !gate_all | closes;
        abort       = gate_all & !verd.pass;
        verd.take   = try_br & verd.pass;
        verd.finish = closes | abort | verd.take;
    end

endmodule

// File: rtl/vbr_target.sv
module vbr_target
    import vbranch_pkg::*;
#(
    parameter int AW   = 64,
    parameter int BD_W = 14
) (
    input  mode_t           md,
    input  logic [AW-1:0]   cia,
    input  logic [BD_W-1:0] disp,
    input  logic [AW-1:0]   lr,
    output logic [AW-1:0]   br_tgt,
    output logic [AW-1:0]   ret_addr
);
    localparam int EXT_W = AW - BD_W - 2;

    logic [AW-1:0] offs;

    always_comb begin
        offs     = {{EXT_W{disp[BD_W-1]}}, disp, 2'b00};
        ret_addr = cia + AW'(4);
        if (md.lrm)
            br_tgt = lr & ~AW'(3);
        else if (md.aa)
            br_tgt = offs;
        else
            br_tgt = cia + offs;
    end

endmodule

// File: rtl/vbranch_eval.sv
module vbranch_eval
    import vbranch_pkg::*;
#(
    parameter int AW   = 64,
    parameter int CR_W = 32,
    parameter int VL_W = 7,
    parameter int BD_W = 14,
    parameter int BI_W = $clog2(CR_W)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [3:0]      bo_in,
    input  logic [BI_W-1:0] bi_in,
    input  logic            sz_in,
    input  logic            snz_in,
    input  logic            mode64_in,
    input  logic            vlset_in,
    input  logic            vl_sense_in,
    input  logic            vl_incl_in,
    input  logic            all_in,
    input  logic            lr_force_in,
    input  logic            link_in,
    input  logic            abs_in,
    input  logic            to_lr_in,
    input  logic [VL_W-1:0] vl_in,
    input  logic [AW-1:0]   ctr_in,
    input  logic [AW-1:0]   cia_in,
    input  logic [BD_W-1:0] disp_in,
    input  logic [AW-1:0]   lr_in,
    input  logic [CR_W-1:0] elem_cr,
    output logic            busy,
    output logic [VL_W-1:0] step,
    output logic            done,
    output logic            taken,
    output logic [AW-1:0]   nia,
    output logic [AW-1:0]   ctr_out,
    output logic            vl_we,
    output logic [VL_W-1:0] vl_out,
    output logic            lr_we,
    output logic [AW-1:0]   lr_out
);
    state_t          state_q;
    bo_t             bo_q;
    mode_t           md_q, md_new;
    logic [BI_W-1:0] bi_q;
    logic [VL_W-1:0] vl_q, step_q;
    logic [AW-1:0]   ctr_q, cia_q, lr_q, nia_q, lr_out_q;
    logic [BD_W-1:0] disp_q;
    logic            done_q, taken_q, vl_we_q, lr_we_q;
    logic [VL_W-1:0] vl_out_q;

    logic [AW-1:0]   ctr_nxt, br_tgt, ret_addr;
    verdict_t        verd;

    always_comb begin
        md_new = '{sz: sz_in, snz: snz_in, m64: mode64_in, vlset: vlset_in,
                   vsb: vl_sense_in, vli: vl_incl_in, all_el: all_in,
                   lru: lr_force_in, lk: link_in, aa: abs_in, lrm: to_lr_in};
    end

    vbr_elem_eval #(.AW(AW), .CR_W(CR_W), .VL_W(VL_W), .BI_W(BI_W)) eval_i (
        .bo(bo_q), .md(md_q), .bi(bi_q), .cr(elem_cr), .ctr(ctr_q),
        .step(step_q), .vl(vl_q), .ctr_nxt(ctr_nxt), .verd(verd)
    );

    vbr_target #(.AW(AW), .BD_W(BD_W)) tgt_i (
        .md(md_q), .cia(cia_q), .disp(disp_q), .lr(lr_q),
        .br_tgt(br_tgt), .ret_addr(ret_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            step_q   <= '0;
            ctr_q    <= '0;
            done_q   <= 1'b0;
            taken_q  <= 1'b0;
            vl_we_q  <= 1'b0;
            lr_we_q  <= 1'b0;
            nia_q    <= '0;
            vl_out_q <= '0;
            lr_out_q <= '0;
            bo_q     <= '0;
            md_q     <= '0;
            bi_q     <= '0;
            vl_q     <= '0;
            cia_q    <= '0;
            lr_q     <= '0;
            disp_q   <= '0;
        end else begin
            done_q  <= 1'b0;
            vl_we_q <= 1'b0;
            lr_we_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (start) begin
                    bo_q    <= unpack_bo(bo_in);
                    md_q    <= md_new;
                    bi_q    <= bi_in;
                    vl_q    <= vl_in;
                    cia_q   <= cia_in;
                    lr_q    <= lr_in;
                    disp_q  <= disp_in;
                    ctr_q   <= ctr_in;
                    step_q  <= '0;
                    taken_q <= 1'b0;
                    if (vl_in == '0 && !to_lr_in) begin
                        done_q <= 1'b1;
                        nia_q  <= cia_in + AW'(4);
                    end else begin
                        state_q <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    ctr_q  <= ctr_nxt;
                    step_q <= step_q + VL_W'(1);
                    if (verd.finish) begin
                        state_q  <= ST_IDLE;
                        done_q   <= 1'b1;
                        taken_q  <= verd.take;
                        nia_q    <= verd.take ? br_tgt : ret_addr;
                        vl_we_q  <= verd.vl_hit;
                        vl_out_q <= md_q.vli ? step_q + VL_W'(1) : step_q;
                        lr_we_q  <= md_q.lk & (md_q.lru | verd.take);
                        lr_out_q <= ret_addr;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state_q == ST_RUN);
    assign step    = step_q;
    assign done    = done_q;
    assign taken   = taken_q;
    assign nia     = nia_q;
    assign ctr_out = ctr_q;
    assign vl_we   = vl_we_q;
    assign vl_out  = vl_out_q;
    assign lr_we   = lr_we_q;
    assign lr_out  = lr_out_q;

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R10
    fallthru_chk: assert property (@(posedge clk) disable iff (rst)
        (done_q && !taken_q) |-> nia_q == cia_q + AW'(4));

    // R2
    ctr_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !bo_q.keep_ctr) |=> ctr_q == $past(ctr_q) - AW'(1));

    // R11
    step_inc_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || step_q == $past(step_q) + VL_W'(1)));

    // R8
    lr_val_chk: assert property (@(posedge clk) disable iff (rst)
        lr_we_q |-> (done_q && lr_out_q == cia_q + AW'(4)));

    // R6
    vl_we_chk: assert property (@(posedge clk) disable iff (rst)
        vl_we_q |-> (done_q && (vl_out_q == $past(step_q) ||
                                vl_out_q == $past(step_q) + VL_W'(1))));

    // R7
    all_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && md_q.all_el && !md_q.lrm && !verd.pass) |=> (done_q && !taken_q));

endmodule

// File: tb/vbranch_eval_tb.sv
module vbranch_eval_tb_top;

    typedef struct packed {
        logic [3:0]  bo;
        logic [4:0]  bi;
        logic [4:0]  hot;
        logic [7:0]  pat;
        logic        sz, snz, m64, vlset, vsb, vli, all_el, lru, lk, aa, lrm;
        logic [6:0]  vl;
        logic [63:0] ctr;
        logic [63:0] e_nia;
        logic [63:0] e_ctr;
        logic        e_vlwe;
        logic [6:0]  e_vl;
        logic        e_lrwe;
        logic        e_taken;
        logic [3:0]  e_n;
    } vec_t;

    localparam logic [63:0] C5   = 64'd5;
    localparam logic [63:0] REL  = 64'h1040;
    localparam logic [63:0] FALL = 64'h1004;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        // R5 R8 R1: element 2 passes, relative target, link written
        '{4'b0110, 5'd0, 5'd31, 8'h04, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 7'd4, C5, REL, C5, 1'b0, 7'd0, 1'b1, 1'b1, 4'd3},
        // R10 R8: nothing passes, no link write without force
        '{4'b0110, 5'd0, 5'd31, 8'h00, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0, 7'd4, C5, FALL, C5, 1'b0, 7'd0, 1'b0, 1'b0, 4'd4},
        // R8: forced link write when not taken
        '{4'b0110, 5'd0, 5'd31, 8'h00, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 7'd4, C5, FALL, C5, 1'b0, 7'd0, 1'b1, 1'b0, 4'd4},
        // R2 R3: branch when count reaches zero
        '{4'b1001, 5'd0, 5'd31, 8'h00, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 7'd8, 64'd3, REL, 64'd0, 1'b0, 7'd0, 1'b0, 1'b1, 4'd3},
        // R3 R5: 32-bit zero test, absolute target
        '{4'b1001, 5'd0, 5'd31, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 7'd4, 64'h1_0000_0002, 64'h40, 64'h1_0000_0000, 1'b0, 7'd0, 1'b0, 1'b1, 4'd2},
        // R3: 64-bit zero test never hits
        '{4'b1001, 5'd0, 5'd31, 8'h00, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 7'd4, 64'h1_0000_0002, FALL, 64'h0_FFFF_FFFE, 1'b0, 7'd0, 1'b0, 1'b0, 4'd4},
        // R6 R7: all mode, truncate on fail, exclusive
        '{4'b0110, 5'd0, 5'd31, 8'hF7, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0, 7'd8, C5, FALL, C5, 1'b1, 7'd3, 1'b0, 1'b0, 4'd4},
        // R6: inclusive length
        '{4'b0110, 5'd0, 5'd31, 8'hF7, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 7'd8, C5, FALL, C5, 1'b1, 7'd4, 1'b0, 1'b0, 4'd4},
        // R7: all pass, branch on last element
        '{4'b0110, 5'd0, 5'd31, 8'hFF, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 7'd5, C5, REL, C5, 1'b0, 7'd0, 1'b1, 1'b1, 4'd5},
        // R7: element 2 fails, abort
        '{4'b0110, 5'd0, 5'd31, 8'hFB, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0, 7'd5, C5, FALL, C5, 1'b0, 7'd0, 1'b0, 1'b0, 4'd3},
        // R6 R5: truncate on pass together with branch
        '{4'b0110, 5'd0, 5'd31, 8'h04, 1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 7'd8, C5, REL, C5, 1'b1, 7'd2, 1'b0, 1'b1, 4'd3},
        // R1: substitute bit 1
        '{4'b0110, 5'd0, 5'd31, 8'h00, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 7'd4, C5, REL, C5, 1'b0, 7'd0, 1'b0, 1'b1, 4'd1},
        // R1: substitute bit 0 overrides set condition words
        '{4'b0110, 5'd0, 5'd31, 8'hFF, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 7'd2, C5, FALL, C5, 1'b0, 7'd0, 1'b0, 1'b0, 4'd2},
        // R9: link-register target, single element
        '{4'b0110, 5'd0, 5'd31, 8'h01, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1, 7'd8, C5, 64'h2000, C5, 1'b0, 7'd0, 1'b1, 1'b1, 4'd1},
        // R9: truncation and all mode have no effect
        '{4'b0110, 5'd0, 5'd31, 8'h00, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 7'd8, C5, FALL, C5, 1'b0, 7'd0, 1'b0, 1'b0, 4'd1},
        // R1: index 0 reads the top bit, bit 0 is not seen
        '{4'b0110, 5'd0, 5'd0,  8'h01, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 7'd1, C5, FALL, C5, 1'b0, 7'd0, 1'b0, 1'b0, 4'd1},
        // R4: ignore condition with kept count
        '{4'b1010, 5'd0, 5'd31, 8'h00, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 7'd3, C5, REL, C5, 1'b0, 7'd0, 1'b0, 1'b1, 4'd1},
        // R2 R3: count wraps below zero then passes non-zero test
        '{4'b1000, 5'd0, 5'd31, 8'h00, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 7'd3, 64'd1, REL, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 7'd0, 1'b0, 1'b1, 4'd2},
        // R10: zero length, no element processed
        '{4'b1000, 5'd0, 5'd31, 8'h00, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 7'd0, C5, FALL, C5, 1'b0, 7'd0, 1'b0, 1'b0, 4'd0},
        // R9 R1: substitute bit ignored in link-register variant
        '{4'b0110, 5'd0, 5'd31, 8'h00, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 7'd8, C5, FALL, C5, 1'b0, 7'd0, 1'b0, 1'b0, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [3:0]  bo_in = '0;
    logic [4:0]  bi_in = '0;
    logic        sz_in = 0, snz_in = 0, mode64_in = 0, vlset_in = 0, vl_sense_in = 0;
    logic        vl_incl_in = 0, all_in = 0, lr_force_in = 0, link_in = 0, abs_in = 0, to_lr_in = 0;
    logic [6:0]  vl_in = '0;
    logic [63:0] ctr_in = '0;
    logic [63:0] cia_in = 64'h1000;
    logic [13:0] disp_in = 14'h0010;
    logic [63:0] lr_in = 64'h2003;
    logic [31:0] elem_cr;
    logic [7:0]  cur_pat = '0;
    logic [4:0]  cur_hot = '0;

    logic        busy, done, taken, vl_we, lr_we;
    logic [6:0]  step, vl_out;
    logic [63:0] nia, ctr_out, lr_out;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    assign elem_cr = (step < 7'd8 && cur_pat[step[2:0]]) ? (32'h1 << cur_hot) : 32'h0;

    vbranch_eval dut_i (
        .clk(clk), .rst(rst), .start(start), .bo_in(bo_in), .bi_in(bi_in),
        .sz_in(sz_in), .snz_in(snz_in), .mode64_in(mode64_in), .vlset_in(vlset_in),
        .vl_sense_in(vl_sense_in), .vl_incl_in(vl_incl_in), .all_in(all_in),
        .lr_force_in(lr_force_in), .link_in(link_in), .abs_in(abs_in), .to_lr_in(to_lr_in),
        .vl_in(vl_in), .ctr_in(ctr_in), .cia_in(cia_in), .disp_in(disp_in), .lr_in(lr_in),
        .elem_cr(elem_cr), .busy(busy), .step(step), .done(done), .taken(taken),
        .nia(nia), .ctr_out(ctr_out), .vl_we(vl_we), .vl_out(vl_out),
        .lr_we(lr_we), .lr_out(lr_out)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load(input vec_t v);
        bo_in = v.bo; bi_in = v.bi; cur_hot = v.hot; cur_pat = v.pat;
        sz_in = v.sz; snz_in = v.snz; mode64_in = v.m64; vlset_in = v.vlset;
        vl_sense_in = v.vsb; vl_incl_in = v.vli; all_in = v.all_el;
        lr_force_in = v.lru; link_in = v.lk; abs_in = v.aa; to_lr_in = v.lrm;
        vl_in = v.vl; ctr_in = v.ctr;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (!done && n < 60) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R12: reset state
        chk("R12 busy after reset", 64'(busy), 64'd0);
        chk("R12 done after reset", 64'(done), 64'd0);
        chk("R12 vl_we/lr_we after reset", 64'({vl_we, lr_we}), 64'd0);
        chk("R12 taken after reset", 64'(taken), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            load(VECS[i]);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            wait_done(n);
            chk($sformatf("R11 element count v%0d", i), 64'(n), 64'(VECS[i].e_n));
            chk($sformatf("R5 R9 R10 nia v%0d", i), nia, VECS[i].e_nia);
            chk($sformatf("R2 R3 ctr_out v%0d", i), ctr_out, VECS[i].e_ctr);
            chk($sformatf("R5 R7 taken v%0d", i), 64'(taken), 64'(VECS[i].e_taken));
            chk($sformatf("R6 vl_we v%0d", i), 64'(vl_we), 64'(VECS[i].e_vlwe));
            if (VECS[i].e_vlwe)
                chk($sformatf("R6 vl_out v%0d", i), 64'(vl_out), 64'(VECS[i].e_vl));
            chk($sformatf("R8 lr_we v%0d", i), 64'(lr_we), 64'(VECS[i].e_lrwe));
            if (VECS[i].e_lrwe)
                chk($sformatf("R8 lr_out v%0d", i), lr_out, FALL);
            @(negedge clk);
            chk($sformatf("R10 done one cycle v%0d", i), 64'({done, vl_we, lr_we}), 64'd0);
        end

        // R11: a second start during a run is ignored
        load(VECS[1]);
        start = 1'b1;
        @(negedge clk);
        vl_in = 7'd1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 60) begin
            @(negedge clk);
            n++;
        end
        chk("R11 start ignored while busy", 64'(n), 64'd4);
        @(negedge clk);

        // R12: reset abandons a loop in progress
        load(VECS[1]);
        vl_in = 7'd8;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R12 busy mid-run", 64'(busy), 64'd1);
        rst = 1'b1;
        @(negedge clk);
        chk("R12 busy cleared by reset", 64'(busy), 64'd0);
        chk("R12 done cleared by reset", 64'(done), 64'd0);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        chk("R12 no late done after reset", 64'(done), 64'd0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule